// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Level Gating

This block gathers interrupt events from a parameterised set of peripheral sources and decides which one, if any, the processor should take. Every source owns a sticky request flag, an enable bit and a 2-bit priority level. Among the sources whose request and enable are both set, the block selects one winner and presents its index and level. The winner is compared with the processor's current 2-bit interrupt level and its global interrupt-enable bit, and the result drives an accept line.

A separate wake line is raised whenever any source is both requesting and enabled. It ignores the level comparison and the global enable, so a core in a low-power mode can be brought back to run. Levels, enables and request clears all arrive through one byte-wide write port.

The address map has three parts. Level registers come first at addresses 0 to NLVL-1, and each holds four 2-bit fields. Enable registers follow, each holding eight bits. Write-one-to-clear registers come last, also eight bits each. All outputs are combinational from the registered flags.

Top module: `irqPrioCtrl`

## Requirements
- R1: After reset all request flags and enable bits are 0, every level field is 3, and winValid, wakeUp and irqAccept are 0.
- R2: A high srcEvent bit sets that source's request flag at the next rising clock edge. The flag stays set until a 1 is written to the source's bit in a clear register. Source s maps to clear address NLVL+NEN+s/8, bit s%8.
- R3: If a clear for a source and an event for the same source occur in the same cycle, the request flag ends up set.
- R4: A source takes part in selection only when its request flag and its enable bit are both 1. Source s's enable bit is at address NLVL+s/8, bit s%8. Disabling a source does not erase its pending request.
- R5: The level of source s is held in level register s/4 at bits [2*(s%4)+1 : 2*(s%4)]. With 12 sources, NLVL=3 and NEN=2, so address 7 is unused.
- R6: winIdx and winLevel name the pending-and-enabled source with the numerically smallest level. When several sources share that level, the one with the lowest index wins. winValid is 1 exactly when some source is pending and enabled.
- R7: irqAccept is 1 exactly when winValid is 1, cpuIntEn is 1, and winLevel is numerically less than cpuLevel. A source at level 3 therefore never causes acceptance.
- R8: wakeUp is 1 exactly when some source is pending and enabled, whatever the levels, cpuLevel and cpuIntEn are.
- R9: A write to an address past the last clear register changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| srcEvent | input | NUM_SRC | Per-source event pulses |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data |
| cpuLevel | input | 2 | Processor's current interrupt level |
| cpuIntEn | input | 1 | Processor's global interrupt enable |
| winIdx | output | IDX_W | Index of the selected source |
| winLevel | output | 2 | Level of the selected source |
| winValid | output | 1 | Some source is pending and enabled |
| irqAccept | output | 1 | Selected request is taken by the processor |
| wakeUp | output | 1 | Wake indication for low-power modes |

## Verification
The bench builds the block with its default 12 sources. At that size the full level/cpuLevel/enable cross product for every single source is small enough to sweep completely. The same is true of every pair of sources at all sixteen level combinations, which exercises every tie and every priority ordering the arbiter can meet. A model in the bench computes the expected winner, accept and wake from its own copy of the flags. Directed steps then cover a clear that collides with an event, the masking of a source while its request stays held, and a write to the unused address.

// File: rtl/irqPrioPkg.sv
package irqPrioPkg;
  localparam int BANK_W = 4;

  typedef struct packed {
    logic              lvlWr;
    logic              enWr;
    logic              clrWr;
    logic [BANK_W-1:0] bank;
  } wrStrobeT;
endpackage

// File: rtl/irqPrioDecode.sv
module irqPrioDecode
  import irqPrioPkg::*;
#(
  parameter int NLVL   = 3,
  parameter int NEN    = 2,
  parameter int ADDR_W = 3
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output wrStrobeT          strobe
);
  int addrInt;

  always_comb begin
    addrInt = int'(wrAddr);
    strobe  = '0;
    if (wrEn) begin
      if (addrInt < NLVL) begin
        strobe.lvlWr = 1'b1;
        strobe.bank  = BANK_W'(addrInt);
      end else if (addrInt < NLVL + NEN) begin
        strobe.enWr = 1'b1;
        strobe.bank = BANK_W'(addrInt - NLVL);
      end else if (addrInt < NLVL + 2 * NEN) begin
        strobe.clrWr = 1'b1;
        strobe.bank  = BANK_W'(addrInt - NLVL - NEN);
      end
    end
  end
endmodule

// File: rtl/irqPrioRegs.sv
module irqPrioRegs
  import irqPrioPkg::*;
#(
  parameter int NUM_SRC = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  wrStrobeT               strobe,
  input  logic [7:0]             wrData,
  input  logic [NUM_SRC-1:0]     srcEvent,
  output logic [NUM_SRC-1:0]     reqFlag,
  output logic [NUM_SRC-1:0]     enFlag,
  output logic [2*NUM_SRC-1:0]   lvlFlat
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : gSrc
    localparam int LB   = s / 4;
    localparam int LF   = s % 4;
    localparam int EB   = s / 8;
    localparam int EBIT = s % 8;

    logic clrHit;
    assign clrHit = strobe.clrWr && (strobe.bank == BANK_W'(EB)) && wrData[EBIT];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        reqFlag[s] <= 1'b0;
      end else begin
        reqFlag[s] <= (reqFlag[s] & ~clrHit) | srcEvent[s];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enFlag[s] <= 1'b0;
      end else if (strobe.enWr && (strobe.bank == BANK_W'(EB))) begin
        enFlag[s] <= wrData[EBIT];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lvlFlat[2*s +: 2] <= 2'b11;
      end else if (strobe.lvlWr && (strobe.bank == BANK_W'(LB))) begin
        lvlFlat[2*s +: 2] <= wrData[2*LF +: 2];
      end
    end
  end
endmodule

// File: rtl/irqPrioArb.sv
module irqPrioArb #(
  parameter int NUM_SRC = 12,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_SRC-1:0]   pendEn,
  input  logic [2*NUM_SRC-1:0] lvlFlat,
  output logic [IDX_W-1:0]     winIdx,
  output logic [1:0]           winLevel,
  output logic                 winValid
);
  logic [2:0] bestLvl;

  always_comb begin
    bestLvl  = 3'b100;
    winIdx   = '0;
    winValid = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pendEn[i] && ({1'b0, lvlFlat[2*i +: 2]} < bestLvl)) begin
        bestLvl  = {1'b0, lvlFlat[2*i +: 2]};
        winIdx   = IDX_W'(i);
        winValid = 1'b1;
      end
    end
    winLevel = bestLvl[1:0];
  end
endmodule

// File: rtl/irqPrioCtrl.sv
module irqPrioCtrl
  import irqPrioPkg::*;
#(
  parameter  int NUM_SRC = 12,
  localparam int NLVL    = (NUM_SRC + 3) / 4,
  localparam int NEN     = (NUM_SRC + 7) / 8,
  localparam int ADDR_W  = $clog2(NLVL + 2 * NEN + 1),
  localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [7:0]         wrData,
  input  logic [1:0]         cpuLevel,
  input  logic               cpuIntEn,
  output logic [IDX_W-1:0]   winIdx,
  output logic [1:0]         winLevel,
  output logic               winValid,
  output logic               irqAccept,
  output logic               wakeUp
);
  wrStrobeT               strobe;
  logic [NUM_SRC-1:0]     reqFlag;
  logic [NUM_SRC-1:0]     enFlag;
  logic [NUM_SRC-1:0]     pendEn;
  logic [2*NUM_SRC-1:0]   lvlFlat;

  irqPrioDecode #(.NLVL(NLVL), .NEN(NEN), .ADDR_W(ADDR_W)) uDec (
    .wrEn(wrEn), .wrAddr(wrAddr), .strobe(strobe)
  );

  irqPrioRegs #(.NUM_SRC(NUM_SRC)) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .srcEvent(srcEvent), .reqFlag(reqFlag), .enFlag(enFlag), .lvlFlat(lvlFlat)
  );

  assign pendEn = reqFlag & enFlag;

  irqPrioArb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) uArb (
    .pendEn(pendEn), .lvlFlat(lvlFlat),
    .winIdx(winIdx), .winLevel(winLevel), .winValid(winValid)
  );

  assign wakeUp    = |pendEn;
  assign irqAccept = winValid && cpuIntEn && (winLevel < cpuLevel);
endmodule

// File: rtl/irqPrioChk.sv
module irqPrioChk #(
  parameter int NUM_SRC = 12,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcEvent,
  input logic [NUM_SRC-1:0] reqFlag,
  input logic [NUM_SRC-1:0] pendEn,
  input logic [IDX_W-1:0]   winIdx,
  input logic [1:0]         winLevel,
  input logic               winValid,
  input logic [1:0]         cpuLevel,
  input logic               cpuIntEn,
  input logic               irqAccept,
  input logic               wakeUp
);
  // R2: a flag can only rise when an event was seen the cycle before
  assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((reqFlag & ~$past(reqFlag) & ~$past(srcEvent)) == '0));

  // R3: an event always leaves the flag set, even when a clear collides
  assert_event_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((~reqFlag & $past(srcEvent)) == '0));

  // R4: the chosen source is one that is pending and enabled
  assert_winner_pending_R4: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> pendEn[winIdx]);

  // R7: acceptance implies the gates held
  assert_accept_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqAccept |-> (cpuIntEn && (winLevel != 2'b11) && (winLevel < cpuLevel)));

  // R8: wake tracks the presence of any selectable source
  assert_wake_matches_R8: assert property (@(posedge clk) disable iff (!rstN)
    wakeUp == winValid);
endmodule

bind irqPrioCtrl irqPrioChk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .reqFlag(reqFlag),
  .pendEn(pendEn), .winIdx(winIdx), .winLevel(winLevel), .winValid(winValid),
  .cpuLevel(cpuLevel), .cpuIntEn(cpuIntEn), .irqAccept(irqAccept), .wakeUp(wakeUp)
);

// File: tb/sim_irqPrioCtrl.sv
module sim_irqPrioCtrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS    = 12;
  localparam int NLVL  = 3;
  localparam int NEN   = 2;
  localparam int AW    = 3;
  localparam int IW    = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] srcEvent = '0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0]    wrData = '0;
  logic [1:0]    cpuLevel = 2'd0;
  logic          cpuIntEn = 1'b0;
  logic [IW-1:0] winIdx;
  logic [1:0]    winLevel;
  logic          winValid, irqAccept, wakeUp;

  int  nTests = 0;
  int  nFail  = 0;
  bit  done   = 0;

  logic [NS-1:0] reqS;
  logic [NS-1:0] enS;
  logic [1:0]    lvlS [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  irqPrioCtrl #(.NUM_SRC(NS)) u0 (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .cpuLevel(cpuLevel), .cpuIntEn(cpuIntEn), .winIdx(winIdx),
    .winLevel(winLevel), .winValid(winValid), .irqAccept(irqAccept), .wakeUp(wakeUp)
  );

  task automatic check(string req, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doWrite(int addr, logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic setLevel(int s, logic [1:0] l);
    logic [7:0] d;
    int r;
    lvlS[s] = l;
    r = s / 4;
    for (int k = 0; k < 4; k++) d[2*k +: 2] = (4*r + k < NS) ? lvlS[4*r + k] : 2'b11;
    doWrite(r, d);
  endtask

  task automatic setEnable(logic [NS-1:0] m);
    logic [15:0] w;
    enS = m;
    w = 16'(m);
    doWrite(NLVL, w[7:0]);
    doWrite(NLVL + 1, w[15:8]);
  endtask

  task automatic clearAll();
    doWrite(NLVL + NEN, 8'hFF);
    doWrite(NLVL + NEN + 1, 8'hFF);
    reqS = '0;
  endtask

  task automatic pulse(logic [NS-1:0] m);
    @(negedge clk);
    srcEvent = m;
    @(negedge clk);
    srcEvent = '0;
    reqS |= m;
  endtask

  task automatic compareAll(string req);
    int bi, bl;
    logic bv;
    bi = 0; bl = 4; bv = 1'b0;
    for (int i = 0; i < NS; i++)
      if (reqS[i] && enS[i] && int'(lvlS[i]) < bl) begin
        bi = i; bl = int'(lvlS[i]); bv = 1'b1;
      end
    check({req, " winValid"}, int'(winValid), int'(bv));
    check({req, " wakeUp R8"}, int'(wakeUp), int'(bv));
    if (bv) begin
      check({req, " winIdx R6"}, int'(winIdx), bi);
      check({req, " winLevel R6"}, int'(winLevel), bl);
    end
    check({req, " irqAccept R7"}, int'(irqAccept),
          int'(bv && cpuIntEn && bl < int'(cpuLevel)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++; nTests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    reqS = '0; enS = '0;
    for (int i = 0; i < NS; i++) lvlS[i] = 2'b11;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 winValid", int'(winValid), 0);
    check("R1 wakeUp", int'(wakeUp), 0);
    check("R1 irqAccept", int'(irqAccept), 0);
    cpuLevel = 2'd3; cpuIntEn = 1'b1;
    setEnable('1);
    pulse(NS'(1) << 5);
    check("R1 reset level", int'(winLevel), 3);
    check("R1 winIdx", int'(winIdx), 5);
    check("R7 level3 never accepted", int'(irqAccept), 0);
    compareAll("R1");
    clearAll();
    check("R2 cleared", int'(wakeUp), 0);

    // single-source sweep: R5, R6, R7, R8
    for (int s = 0; s < NS; s++) begin
      for (int l = 0; l < 4; l++) begin
        setLevel(s, 2'(l));
        pulse(NS'(1) << s);
        for (int cl = 0; cl < 4; cl++)
          for (int ie = 0; ie < 2; ie++) begin
            cpuLevel = 2'(cl); cpuIntEn = ie[0];
            #1;
            compareAll("R5 single");
          end
        clearAll();
        check("R2 clear single", int'(wakeUp), 0);
      end
      setLevel(s, 2'b11);
    end

    // pair sweep: ties and ordering R6
    cpuLevel = 2'd2; cpuIntEn = 1'b1;
    for (int i = 0; i < NS; i++)
      for (int j = i + 1; j < NS; j++)
        for (int li = 0; li < 4; li++)
          for (int lj = 0; lj < 4; lj++) begin
            setLevel(i, 2'(li));
            setLevel(j, 2'(lj));
            pulse((NS'(1) << i) | (NS'(1) << j));
            compareAll("R6 pair");
            clearAll();
            setLevel(i, 2'b11);
            setLevel(j, 2'b11);
          end

    // R2: flag holds without events, clear of other source leaves it
    setLevel(3, 2'd1);
    pulse(NS'(1) << 3);
    repeat (5) @(negedge clk);
    check("R2 hold", int'(wakeUp), 1);
    doWrite(NLVL + NEN, 8'h04);
    check("R2 other clear", int'(winIdx), 3);
    doWrite(NLVL + NEN, 8'h08);
    reqS = '0;
    check("R2 own clear", int'(wakeUp), 0);

    // R3: clear and event in the same cycle
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(NLVL + NEN); wrData = 8'h08;
    srcEvent = NS'(1) << 3;
    @(negedge clk);
    wrEn = 1'b0; srcEvent = '0;
    reqS[3] = 1'b1;
    check("R3 collide kept", int'(wakeUp), 1);
    compareAll("R3");

    // R4: masking keeps request pending
    setEnable('1 & ~(NS'(1) << 3));
    check("R4 masked wake", int'(wakeUp), 0);
    check("R4 masked accept", int'(irqAccept), 0);
    setEnable('1);
    check("R4 reenabled", int'(winIdx), 3);
    compareAll("R4");

    // R9: unused address
    pulse(NS'(1) << 9);
    doWrite(7, 8'hFF);
    compareAll("R9 unused write");
    check("R9 level kept", int'(winLevel), 1);
    setLevel(3, 2'b11);
    compareAll("R9 after");
    check("R9 idx", int'(winIdx), 3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule